// File: doc/BRIEF.md
# Sequencer Address and Strobe Expander

This block turns a narrow 12-line sequencer word into the wider control set that a pixel array readout needs. The outputs are an 8-bit row address, an 8-bit column address and five timing strobes: signal sample, reference sample, clamp, transfer gate and pixel reset. The lowest input line picks the mode. The meaning of every other line depends on that mode.

In opcode mode (mode line low), five lines drive the strobes, and two 3-bit fields each give a command to one address axis. An axis can step up or down, be forced to all zeros or all ones, copy its address into a private bookmark register, or take its address back from that bookmark in one clock. The bookmark lets a raster scan of a sub-window jump back to its first column at the start of every row. In load mode (mode line high), eight lines carry an address value, one line picks the axis and one line writes the value. The strobes are held in their idle levels while this mode is active.

The input word is sampled on every rising clock edge. The outputs are registers, so each change appears one clock after the word that causes it.

Top module: `seq_addr_expander`

## Requirements
- R1: While reset is held, both addresses read 0x00 and the strobes sit idle: transfer gate high, the other four low. Both bookmark registers are also cleared, so a recall issued right after reset gives 0x00.
- R2: When bit 0 = 0, input bits 1..5 appear one clock later on the outputs signal sample, reference sample, clamp, transfer gate and pixel reset, in that order.
- R3: When bit 0 = 0, bits 8:6 hold the row command and bits 11:9 hold the column command. The two axes act independently in the same clock.
- R4: Command 101 adds one to the axis address, and 0xFF wraps to 0x00.
- R5: Command 001 subtracts one from the axis address, and 0x00 wraps to 0xFF.
- R6: Command 010 loads 0x00 into the axis address, and command 011 loads 0xFF.
- R7: Command 100 copies the address into that axis's bookmark and leaves the address unchanged. Command 110 copies the bookmark back into the address.
- R8: Commands 000 and 111 leave the address and the bookmark unchanged.
- R9: When bit 0 = 1, bits 8:1 form the value (bit 1 is its LSB). Bit 9 selects the axis (0 = row, 1 = column), and bit 10 = 1 writes the value into that axis one clock later.
- R10: When bit 0 = 1, the strobes are forced idle (transfer gate high, the rest low), whatever the levels on bits 1..5.
- R11: When bit 0 = 1 and bit 10 = 0, neither address and neither bookmark changes, whatever the levels on the other bits, bit 11 included.
- R12: A command held on the inputs for N clocks takes effect N times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| seq_i | input | 12 | Sequencer word; bit 0 selects the mode |
| row_addr_o | output | 8 | Row address register |
| col_addr_o | output | 8 | Column address register |
| samp_sig_o | output | 1 | Signal-level sample strobe |
| samp_ref_o | output | 1 | Reference-level sample strobe |
| clamp_o | output | 1 | Column clamp strobe |
| xfer_gate_o | output | 1 | Transfer gate; idle level high |
| pix_rst_o | output | 1 | Pixel reset strobe |

## Verification
The embedded properties assume that the sequencer word holds known values at every rising edge once reset has been released. They also assume that reset is asserted from time zero, so that every `$past` value they use is a reset value or a sampled word. The stimulus meets both assumptions: it drives the word only on falling edges, starts with an all-zero word while reset is low, and never leaves a line undriven. Because each axis property is triggered only by its own decoded command or load pulse, the stimulus can mix commands freely across the two axes and across modes without breaking any property.

// File: rtl/seq_addr_expander_pkg.sv
package seq_addr_expander_pkg;

  localparam int ADDR_W     = 8;
  localparam int OP_W       = 3;
  localparam int STB_N      = 5;
  localparam int N_AXES     = 2;

  // opcode-mode slice positions
  localparam int MODE_BIT   = 0;
  localparam int STB_LSB    = MODE_BIT + 1;
  localparam int ROW_OP_LSB = STB_LSB + STB_N;
  localparam int SEQ_W      = ROW_OP_LSB + N_AXES * OP_W;

  // load-mode slice positions
  localparam int VAL_LSB    = MODE_BIT + 1;
  localparam int AXIS_BIT   = VAL_LSB + ADDR_W;
  localparam int LOAD_BIT   = AXIS_BIT + 1;

  // strobe vector order: {pix_rst, xfer_gate, clamp, samp_ref, samp_sig}
  localparam int XFER_IDX   = 3;
  localparam logic [STB_N-1:0] STB_IDLE = STB_N'(1) << XFER_IDX;

  typedef enum logic [OP_W-1:0] {
    OP_HOLD   = 3'b000,
    OP_DEC    = 3'b001,
    OP_ZERO   = 3'b010,
    OP_ONES   = 3'b011,
    OP_SAVE   = 3'b100,
    OP_INC    = 3'b101,
    OP_RECALL = 3'b110,
    OP_HOLD2  = 3'b111
  } axis_op_e;

  function automatic logic [ADDR_W-1:0] next_addr(
    input logic [ADDR_W-1:0] cur,
    input axis_op_e          op,
    input logic [ADDR_W-1:0] mark
  );
    logic [ADDR_W-1:0] nxt;
    case (op)
      OP_INC:    nxt = cur + ADDR_W'(1);
      OP_DEC:    nxt = cur - ADDR_W'(1);
      OP_ZERO:   nxt = '0;
      OP_ONES:   nxt = '1;
      OP_RECALL: nxt = mark;
      default:   nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/addr_axis.sv
module addr_axis
  import seq_addr_expander_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  axis_op_e          op,
  input  logic              ld_fire,
  input  logic [ADDR_W-1:0] ld_val,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] mark_q;
  logic              do_save;
  logic              do_step;
  logic              is_idle;

  assign do_save = op_valid && (op == OP_SAVE);
  assign do_step = op_valid && !do_save;
  assign is_idle = !ld_fire && (!op_valid || op == OP_HOLD || op == OP_HOLD2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      mark_q <= '0;
    end else begin
      if (ld_fire)
        addr_q <= ld_val;
      else if (do_step)
        addr_q <= next_addr(addr_q, op, mark_q);
      if (do_save)
        mark_q <= addr_q;
    end
  end

  assign addr_o = addr_q;

  assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fire |=> addr_o == $past(ld_val));

  assert_inc_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_INC && !ld_fire) |=> addr_o == ADDR_W'($past(addr_o) + 1'b1));

  assert_dec_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_DEC && !ld_fire) |=> addr_o == ADDR_W'($past(addr_o) - 1'b1));

  assert_save_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_save && !ld_fire) |=> $stable(addr_o) && mark_q == $past(addr_o));

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_idle |=> $stable(addr_o) && $stable(mark_q));

endmodule

// File: rtl/strobe_gate.sv
module strobe_gate
  import seq_addr_expander_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             force_idle,
  input  logic [STB_N-1:0] raw_i,
  output logic [STB_N-1:0] stb_o
);

  logic [STB_N-1:0] gated;
  logic [STB_N-1:0] stb_q;

  assign gated = force_idle ? STB_IDLE : raw_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= STB_IDLE;
    else        stb_q <= gated;
  end

  assign stb_o = stb_q;

  assert_forced_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    force_idle |=> stb_o == STB_IDLE);

  assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !force_idle |=> stb_o == $past(raw_i));

endmodule

// File: rtl/seq_addr_expander.sv
module seq_addr_expander
  import seq_addr_expander_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEQ_W-1:0]  seq_i,
  output logic [ADDR_W-1:0] row_addr_o,
  output logic [ADDR_W-1:0] col_addr_o,
  output logic              samp_sig_o,
  output logic              samp_ref_o,
  output logic              clamp_o,
  output logic              xfer_gate_o,
  output logic              pix_rst_o
);

  logic                   load_mode;
  logic                   load_pulse;
  logic                   axis_sel;
  logic [ADDR_W-1:0]      load_val;
  logic [ADDR_W-1:0]      addr_w [N_AXES];
  logic [STB_N-1:0]       stb_w;

  assign load_mode  = seq_i[MODE_BIT];
  assign load_pulse = load_mode && seq_i[LOAD_BIT];
  assign axis_sel   = seq_i[AXIS_BIT];
  assign load_val   = seq_i[VAL_LSB +: ADDR_W];

  for (genvar g = 0; g < N_AXES; g++) begin : g_axis
    addr_axis u_axis (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_valid (!load_mode),
      .op       (axis_op_e'(seq_i[ROW_OP_LSB + g*OP_W +: OP_W])),
      .ld_fire  (load_pulse && (axis_sel == g[0])),
      .ld_val   (load_val),
      .addr_o   (addr_w[g])
    );
  end

  strobe_gate u_stb (
    .clk        (clk),
    .rst_n      (rst_n),
    .force_idle (load_mode),
    .raw_i      (seq_i[STB_LSB +: STB_N]),
    .stb_o      (stb_w)
  );

  assign row_addr_o  = addr_w[0];
  assign col_addr_o  = addr_w[1];
  assign samp_sig_o  = stb_w[0];
  assign samp_ref_o  = stb_w[1];
  assign clamp_o     = stb_w[2];
  assign xfer_gate_o = stb_w[XFER_IDX];
  assign pix_rst_o   = stb_w[4];

  assert_load_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (load_mode && !seq_i[LOAD_BIT]) |=> $stable(row_addr_o) && $stable(col_addr_o));

  assert_strobe_known_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({samp_sig_o, samp_ref_o, clamp_o, xfer_gate_o, pix_rst_o}));

endmodule

// File: tb/seq_addr_expander_bench.sv
module seq_addr_expander_bench;

  localparam logic [2:0] K_NOP = 3'b000, K_DEC = 3'b001, K_ZRO = 3'b010, K_ONE = 3'b011,
                         K_SAV = 3'b100, K_INC = 3'b101, K_RCL = 3'b110, K_NP7 = 3'b111;
  localparam logic [4:0] IDLE = 5'b01000;

  function automatic logic [11:0] mk0(input logic [2:0] c, input logic [2:0] r, input logic [4:0] s);
    return {c, r, s, 1'b0};
  endfunction

  function automatic logic [11:0] mk1(input logic b11, input logic ld, input logic ax, input logic [7:0] v);
    return {b11, ld, ax, v, 1'b1};
  endfunction

  localparam int NV = 16;
  // {seq, row, col, strobes{pix_rst,xfer,clamp,ref,sig}}
  localparam logic [32:0] TBL [NV] = '{
    {mk0(K_NOP, K_INC, 5'b00001), 8'h01, 8'h00, 5'b00001},
    {mk0(K_DEC, K_INC, 5'b00010), 8'h02, 8'hFF, 5'b00010},
    {mk0(K_INC, K_ONE, 5'b00100), 8'hFF, 8'h00, 5'b00100},
    {mk0(K_NOP, K_INC, 5'b01000), 8'h00, 8'h00, 5'b01000},
    {mk0(K_ONE, K_DEC, 5'b10000), 8'hFF, 8'hFF, 5'b10000},
    {mk0(K_DEC, K_SAV, 5'b11111), 8'hFF, 8'hFE, 5'b11111},
    {mk0(K_SAV, K_ZRO, 5'b00000), 8'h00, 8'hFE, 5'b00000},
    {mk0(K_INC, K_INC, 5'b00000), 8'h01, 8'hFF, 5'b00000},
    {mk0(K_RCL, K_RCL, 5'b00000), 8'hFF, 8'hFE, 5'b00000},
    {mk0(K_NP7, K_NP7, 5'b10101), 8'hFF, 8'hFE, 5'b10101},
    {mk1(1'b0, 1'b1, 1'b0, 8'h3C), 8'h3C, 8'hFE, IDLE},
    {mk1(1'b0, 1'b1, 1'b1, 8'hA5), 8'h3C, 8'hA5, IDLE},
    {mk1(1'b1, 1'b0, 1'b0, 8'h77), 8'h3C, 8'hA5, IDLE},
    {mk0(K_RCL, K_RCL, 5'b00000), 8'hFF, 8'hFE, 5'b00000},
    {mk0(K_ZRO, K_INC, 5'b00011), 8'h00, 8'h00, 5'b00011},
    {mk0(K_DEC, K_DEC, 5'b00000), 8'hFF, 8'hFF, 5'b00000}
  };

  localparam string TAG [NV] = '{
    "R2 R3 R4", "R2 R5", "R2 R6 R4", "R2 R4", "R6 R5", "R7 R5 R2", "R7 R6", "R4",
    "R7", "R8 R2", "R9 R10", "R9", "R11", "R7", "R6 R4", "R5"
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] seq_i = '0;
  logic [7:0]  row_addr_o, col_addr_o;
  logic        samp_sig_o, samp_ref_o, clamp_o, xfer_gate_o, pix_rst_o;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  seq_addr_expander u_seq_addr_expander (
    .clk(clk), .rst_n(rst_n), .seq_i(seq_i),
    .row_addr_o(row_addr_o), .col_addr_o(col_addr_o),
    .samp_sig_o(samp_sig_o), .samp_ref_o(samp_ref_o), .clamp_o(clamp_o),
    .xfer_gate_o(xfer_gate_o), .pix_rst_o(pix_rst_o)
  );

  task automatic check(input string tag, input logic [7:0] er, input logic [7:0] ec, input logic [4:0] es);
    logic [20:0] got, exp;
    got = {row_addr_o, col_addr_o, pix_rst_o, xfer_gate_o, clamp_o, samp_ref_o, samp_sig_o};
    exp = {er, ec, es};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got row=%h col=%h stb=%b, expected row=%h col=%h stb=%b",
               tag, got[20:13], got[12:5], got[4:0], er, ec, es);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 8'h00, 8'h00, IDLE);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      seq_i = TBL[i][32:21];
      @(negedge clk);
      check(TAG[i], TBL[i][20:13], TBL[i][12:5], TBL[i][4:0]);
    end
    // R12: command held five clocks steps five times
    seq_i = mk0(K_INC, K_INC, 5'b00000);
    repeat (5) @(negedge clk);
    check("R12 held", 8'h04, 8'h04, 5'b00000);
    // R1: reset again mid-run clears addresses and bookmarks
    rst_n = 1'b0;
    seq_i = '0;
    @(negedge clk);
    check("R1 rereset", 8'h00, 8'h00, IDLE);
    rst_n = 1'b1;
    seq_i = mk0(K_RCL, K_RCL, 5'b00000);
    @(negedge clk);
    check("R1 R7 recall after reset", 8'h00, 8'h00, 5'b00000);
    // R11: load mode without load bit, opcode-looking bits set
    seq_i = mk1(1'b1, 1'b0, 1'b1, 8'hFF);
    @(negedge clk);
    check("R11 R10 quiet", 8'h00, 8'h00, IDLE);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: all requirements, got no completion, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule